// File: doc/BRIEF.md
# Narrow Register Bus Slice with Atomic Multi-Byte Access

This block places one register that is wider than the bus onto a narrow, single-cycle register bus. The register occupies a run of consecutive byte addresses, with byte 0 at the base address and each higher byte one address above the last. The bus offers an address, write data, a write strobe, a read strobe and read data. Every access completes in one cycle, like an SRAM, and there is no acknowledge.

Atomicity is provided by the slice, not by the register. A read of byte 0 returns the live low byte and also copies every higher byte into a shadow buffer in the same cycle. Later reads of the higher bytes return that copy, so a core-side update between the byte reads cannot tear the value. Writes to every byte except the top one go into a staging buffer. A write to the top byte merges the staged bytes and the new top byte into the register in a single cycle. The core can also load the register through its own port.

Read data is driven only for a read that hits this slice. In every other case it is zero, so the returns of many such slices can be combined with a plain OR instead of a multiplexer.

Top module: `csr_narrow_bridge`

## Requirements
- R1: After reset the read data is 0, `reg_value` equals the parameter `RESET_VAL`, and the shadow and staging buffers hold 0.
- R2: In a cycle with no read strobe, or with a read address outside `BASE_ADDR` to `BASE_ADDR+NUM_BYTES-1`, the read data one cycle later is 0.
- R3: A read at `BASE_ADDR` returns bits [DATA_W-1:0] of the register as they are in the read-strobe cycle, and this value appears one cycle after the strobe.
- R4: A read at `BASE_ADDR` copies register bytes 1 to NUM_BYTES-1 into the shadow buffer. A later read at `BASE_ADDR+k` (k≥1) returns the copy of byte k even if the register has changed since the copy was taken.
- R5: A read of a non-first byte with no earlier read of byte 0 since reset returns the shadow buffer contents, which are 0 after reset.
- R6: A write at `BASE_ADDR+k`, with k below NUM_BYTES-1, only stages the byte. `reg_value` does not change.
- R7: A write at `BASE_ADDR+NUM_BYTES-1` loads the register, one cycle later, with the write data as the top byte and the staged bytes below it, staged byte k at bits [k*DATA_W +: DATA_W].
- R8: When a top-byte write and `hw_load` occur in the same cycle, the bus write wins and `hw_value` is dropped.
- R9: When `hw_load` is high and there is no top-byte write, `reg_value` equals `hw_value` one cycle later.
- R10: A write to an address outside the register's range leaves `reg_value` and the staging buffer unchanged.
- R11: Byte k of the register is mapped to address `BASE_ADDR+k`, in little-endian order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data, 0 when not addressed |
| hw_load | input | 1 | Core-side load of the whole register |
| hw_value | input | NUM_BYTES*DATA_W | Value loaded by `hw_load` |
| reg_value | output | NUM_BYTES*DATA_W | Current register contents |

## Verification
The assertions assume that all inputs settle well away from the rising clock edge, that reset is synchronous, and that `NUM_BYTES` is at least 2, so a distinct top byte exists to commit the write. They place no ordering rule on the bus: reads of higher bytes without a prior byte-0 read, writes that overlap `hw_load`, and accesses outside the range are all legal. The bench therefore drives every strobe on the falling edge, holds it for one full cycle and samples the results on the next falling edge. Its directed scenarios include these unordered cases on purpose, so that the defined stale-buffer and priority behaviour is exercised.

// File: rtl/csr_nb_pkg.sv
package csr_nb_pkg;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_SNAP = 2'd1,
        RD_BUF  = 2'd2
    } rd_op_t;

    typedef enum logic [1:0] {
        WR_NONE   = 2'd0,
        WR_STAGE  = 2'd1,
        WR_COMMIT = 2'd2
    } wr_op_t;

endpackage

// File: rtl/csr_nb_decode.sv
module csr_nb_decode
    import csr_nb_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BYTES = 4,
    parameter int BASE_ADDR = 'h40,
    localparam int IDX_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    output rd_op_t            rd_op,
    output wr_op_t            wr_op,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-1:0] offset;
    logic              hit;

    always_comb begin
        offset = addr - ADDR_W'(BASE_ADDR);
        hit    = (offset < ADDR_W'(NUM_BYTES));
        idx    = offset[IDX_W-1:0];

        rd_op = RD_NONE;
        if (re && hit) begin
            rd_op = (idx == '0) ? RD_SNAP : RD_BUF;
        end

        wr_op = WR_NONE;
        if (we && hit) begin
            wr_op = (idx == IDX_W'(NUM_BYTES - 1)) ? WR_COMMIT : WR_STAGE;
        end
    end
endmodule

// File: rtl/csr_nb_wrpath.sv
module csr_nb_wrpath
    import csr_nb_pkg::*;
#(
    parameter int          DATA_W    = 8,
    parameter int          NUM_BYTES = 4,
    parameter logic [NUM_BYTES*DATA_W-1:0] RESET_VAL = '0,
    localparam int         REG_W     = NUM_BYTES * DATA_W,
    localparam int         STG_W     = (NUM_BYTES - 1) * DATA_W,
    localparam int         IDX_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_op_t            wr_op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hw_load,
    input  logic [REG_W-1:0]  hw_value,
    output logic [REG_W-1:0]  value
);
    typedef struct packed {
        logic [STG_W-1:0] stage;
        logic [REG_W-1:0] value;
    } wr_state_t;

    wr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_op == WR_STAGE) begin
            for (int b = 0; b < NUM_BYTES - 1; b++) begin
                if (idx == IDX_W'(b)) begin
                    st_d.stage[b*DATA_W +: DATA_W] = wdata;
                end
            end
        end
        if (wr_op == WR_COMMIT) begin
            st_d.value = {wdata, st_q.stage};
        end else if (hw_load) begin
            st_d.value = hw_value;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stage <= '0;
            st_q.value <= RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.value;

    // R6: staging a lower byte never disturbs the register
    a_r6_stage_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op == WR_STAGE && !hw_load) |=> $stable(value));

    // R7: the top byte of a commit comes from the bus write data
    a_r7_commit_top: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op == WR_COMMIT) |=> (value[REG_W-1 -: DATA_W] == $past(wdata)));

    // R9: a core load without a competing commit takes the core value
    a_r9_hw_load: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_load && wr_op != WR_COMMIT) |=> (value == $past(hw_value)));
endmodule

// File: rtl/csr_nb_rdpath.sv
module csr_nb_rdpath
    import csr_nb_pkg::*;
#(
    parameter int  DATA_W    = 8,
    parameter int  NUM_BYTES = 4,
    localparam int REG_W     = NUM_BYTES * DATA_W,
    localparam int STG_W     = (NUM_BYTES - 1) * DATA_W,
    localparam int IDX_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rd_op_t            rd_op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [REG_W-1:0]  live,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [STG_W-1:0]  shadow;
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        case (rd_op)
            RD_SNAP: begin
                st_d.rdata  = live[DATA_W-1:0];
                st_d.shadow = live[REG_W-1:DATA_W];
            end
            RD_BUF: begin
                for (int b = 1; b < NUM_BYTES; b++) begin
                    if (idx == IDX_W'(b)) begin
                        st_d.rdata = st_q.shadow[(b-1)*DATA_W +: DATA_W];
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

    // R3: byte 0 is the live low byte, one cycle after the strobe
    a_r3_first_live: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_op == RD_SNAP) |=> (rdata == $past(live[DATA_W-1:0])));

    // R4: the shadow only moves on a first-byte read
    a_r4_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_op != RD_SNAP) |=> $stable(st_q.shadow));
endmodule

// File: rtl/csr_narrow_bridge.sv
module csr_narrow_bridge
    import csr_nb_pkg::*;
#(
    parameter int  ADDR_W    = 8,
    parameter int  DATA_W    = 8,
    parameter int  NUM_BYTES = 4,
    parameter int  BASE_ADDR = 'h40,
    parameter logic [NUM_BYTES*DATA_W-1:0] RESET_VAL = 32'hA5C3_0F12,
    localparam int REG_W     = NUM_BYTES * DATA_W,
    localparam int IDX_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              hw_load,
    input  logic [REG_W-1:0]  hw_value,
    output logic [REG_W-1:0]  reg_value
);
    rd_op_t           rd_op;
    wr_op_t           wr_op;
    logic [IDX_W-1:0] idx;

    csr_nb_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_BYTES(NUM_BYTES),
        .BASE_ADDR(BASE_ADDR)
    ) u_decode (
        .addr (bus_addr),
        .we   (bus_we),
        .re   (bus_re),
        .rd_op(rd_op),
        .wr_op(wr_op),
        .idx  (idx)
    );

    csr_nb_wrpath #(
        .DATA_W   (DATA_W),
        .NUM_BYTES(NUM_BYTES),
        .RESET_VAL(RESET_VAL)
    ) u_wrpath (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_op   (wr_op),
        .idx     (idx),
        .wdata   (bus_wdata),
        .hw_load (hw_load),
        .hw_value(hw_value),
        .value   (reg_value)
    );

    csr_nb_rdpath #(
        .DATA_W   (DATA_W),
        .NUM_BYTES(NUM_BYTES)
    ) u_rdpath (
        .clk  (clk),
        .rst_n(rst_n),
        .rd_op(rd_op),
        .idx  (idx),
        .live (reg_value),
        .rdata(bus_rdata)
    );

    // R2: no addressed read means a zero return for the OR combine
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_op == RD_NONE) |=> (bus_rdata == '0));

    // R8: a commit coinciding with a core load keeps the bus top byte
    a_r8_bus_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op == WR_COMMIT && hw_load) |=>
            (reg_value[REG_W-1 -: DATA_W] == $past(bus_wdata)));
endmodule

// File: tb/csr_narrow_bridge_tb.sv
module csr_narrow_bridge_tb_top;
    localparam int          ADDR_W = 8;
    localparam int          DATA_W = 8;
    localparam int          NB     = 4;
    localparam int          BASE   = 'h40;
    localparam logic [31:0] RSTV   = 32'hA5C3_0F12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic              bus_re = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic              hw_load = 1'b0;
    logic [31:0]       hw_value = '0;
    logic [31:0]       reg_value;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    csr_narrow_bridge #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BYTES(NB),
        .BASE_ADDR(BASE), .RESET_VAL(RSTV)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .hw_load(hw_load), .hw_value(hw_value), .reg_value(reg_value)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one bus cycle driven on the falling edge; results sampled one cycle later
    task automatic cyc(input logic [7:0] a, input logic [7:0] wd, input logic we,
                       input logic re, input logic hl, input logic [31:0] hv);
        bus_addr = a; bus_wdata = wd; bus_we = we; bus_re = re;
        hw_load = hl; hw_value = hv;
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0; hw_load = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        cyc(a, 8'h00, 1'b0, 1'b1, 1'b0, 32'h0);
        d = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cyc(a, d, 1'b1, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_reset;
        check("R1 rdata", {24'h0, bus_rdata}, 32'h0);
        check("R1 reg_value", reg_value, RSTV);
    endtask

    task automatic t_stale;
        logic [7:0] d;
        rd(8'(BASE + 2), d);
        check("R5 stale byte2 after reset", {24'h0, d}, 32'h0);
        rd(8'(BASE + 3), d);
        check("R5 stale byte3 after reset", {24'h0, d}, 32'h0);
    endtask

    task automatic t_byte_map;
        logic [7:0] d;
        rd(8'(BASE), d);
        check("R3 byte0 live", {24'h0, d}, 32'h12);
        rd(8'(BASE + 1), d);
        check("R11 byte1 order", {24'h0, d}, 32'h0F);
        rd(8'(BASE + 2), d);
        check("R11 byte2 order", {24'h0, d}, 32'hC3);
        rd(8'(BASE + 3), d);
        check("R11 byte3 order", {24'h0, d}, 32'hA5);
    endtask

    task automatic t_atomic;
        logic [7:0] d;
        rd(8'(BASE), d);
        check("R3 byte0 before load", {24'h0, d}, 32'h12);
        cyc(8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 32'h1122_3344);
        check("R9 hw_load", reg_value, 32'h1122_3344);
        rd(8'(BASE + 1), d);
        check("R4 byte1 from snapshot", {24'h0, d}, 32'h0F);
        rd(8'(BASE + 3), d);
        check("R4 byte3 from snapshot", {24'h0, d}, 32'hA5);
    endtask

    task automatic t_write;
        wr(8'(BASE), 8'hDE);
        check("R6 byte0 staged only", reg_value, 32'h1122_3344);
        check("R2 rdata zero after write", {24'h0, bus_rdata}, 32'h0);
        wr(8'(BASE + 1), 8'hAD);
        wr(8'(BASE + 2), 8'hBE);
        check("R6 bytes1-2 staged only", reg_value, 32'h1122_3344);
        wr(8'(BASE + 3), 8'hEF);
        check("R7 commit merge", reg_value, 32'hEFBE_ADDE);
    endtask

    task automatic t_out_of_range;
        logic [7:0] d;
        wr(8'(BASE + 4), 8'h55);
        wr(8'(BASE - 1), 8'h66);
        check("R10 out-of-range write", reg_value, 32'hEFBE_ADDE);
        rd(8'(BASE + 4), d);
        check("R2 read above range", {24'h0, d}, 32'h0);
        rd(8'(BASE - 1), d);
        check("R2 read below range", {24'h0, d}, 32'h0);
        cyc(8'(BASE), 8'h00, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R2 addressed but no strobe", {24'h0, bus_rdata}, 32'h0);
        // staging untouched: commit a new top byte and look at the lower bytes
        wr(8'(BASE + 3), 8'h01);
        check("R10 staging kept", reg_value, 32'h01BE_ADDE);
    endtask

    task automatic t_priority;
        logic [7:0] d;
        cyc(8'(BASE + 3), 8'h77, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF);
        check("R8 bus commit beats hw_load", reg_value, 32'h77BE_ADDE);
        rd(8'(BASE), d);
        check("R3 byte0 after commit", {24'h0, d}, 32'hDE);
        rd(8'(BASE + 3), d);
        check("R4 byte3 fresh snapshot", {24'h0, d}, 32'h77);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stale();
        t_byte_map();
        t_atomic();
        t_write();
        t_out_of_range();
        t_priority();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule